// File: doc/BRIEF.md
# Bidirectional Latched and Registered Bus Transceiver

This block joins two parallel buses, called A and B, through two independent data paths: one carries A toward B, the other carries B toward A. Each path holds a single storage cell that works in one of three ways, chosen by its control inputs. It can pass data straight through, hold the last value, or capture on a rising edge of a per-path capture clock, with a clock-enable that can block the capture. Data is never inverted.

Each bus side drives two outputs: a data value and an output-enable flag. A pad ring or bus fabric outside the block combines them into a three-state driver. The per-path output enable input is active low, and a high level turns the path into high impedance. The block runs on one system clock. All path controls are treated as synchronous inputs sampled on that clock. A capture edge is a capture-clock input that was low at one system-clock edge and high at the next. Synchronous reset clears both storage cells and holds every output enable off, so the buses come up undriven.

Top module: `bus_xcvr`

## Requirements
- R1: While a path's latch enable is high, its data output equals its data input in the same cycle, bit for bit and uninverted, across all DATA_W bits.
- R2: While the latch enable is high, the storage cell loads the input at every system-clock edge. When the latch enable drops while the capture clock is low, the output keeps the last value seen with the latch enable high.
- R3: While the latch enable is low and the capture clock is held high or held low, the stored value and the output do not change, whatever the data input does.
- R4: While the latch enable is low and the clock-enable is low (active), a capture edge stores the data input present at that system-clock edge.
- R5: While the clock-enable is high, a capture edge leaves the stored value unchanged.
- R6: A path's output-enable output is 1 exactly when its active-low output enable input is 0 and reset is not asserted. The data output does not depend on the output enable, so a path may be transparent while disabled.
- R7: The two paths are independent. Controls and data of one path change neither the output nor the enable of the other.
- R8: While reset is high, both output enables are 0. At the first edge with reset high, both storage cells clear to zero.
- R9: When the latch enable drops while the capture clock is already high, nothing is captured until the capture clock has been low and then rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | DATA_W | Data seen on the A bus |
| b_in | input | DATA_W | Data seen on the B bus |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable (high = transparent) |
| ab_cp | input | 1 | A-to-B capture clock |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable (high = transparent) |
| ba_cp | input | 1 | B-to-A capture clock |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| b_out | output | DATA_W | Data to drive onto the B bus |
| b_oe | output | 1 | B bus driver enable |
| a_out | output | DATA_W | Data to drive onto the A bus |
| a_oe | output | 1 | A bus driver enable |

## Verification
The bench builds the block with the default DATA_W of 18. That width lets the walking patterns 0x3FFFF, 0x2AAAA and 0x15555 toggle every bit in both polarities, so a dropped or inverted bit shows in the output. The same vector table runs first on the A-to-B path and then on the B-to-A path, while the bench checks that the idle path stays quiet. This covers the latch-fall cases with the capture clock low and with it high, the enable transitions during transparent mode, and reset in the middle of operation.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

    typedef struct packed {
        logic oe_n;
        logic le;
        logic cp;
        logic ce_n;
    } path_ctl_t;

    typedef enum logic [1:0] {
        CELL_PASS = 2'd0,
        CELL_HOLD = 2'd1,
        CELL_LOAD = 2'd2
    } cell_op_t;

    localparam int NUM_PATHS = 2;

    function automatic cell_op_t pick_op(input logic le, input logic cp_rise,
                                         input logic ce_n);
        if (le)
            return CELL_PASS;
        else if (cp_rise && !ce_n)
            return CELL_LOAD;
        else
            return CELL_HOLD;
    endfunction

endpackage

// File: rtl/bus_xcvr_edge.sv
module bus_xcvr_edge (
    input  logic clk,
    input  logic cp,
    output logic rise
);
    logic cp_q;

    always_ff @(posedge clk) begin
        cp_q <= cp;
    end

    assign rise = cp & ~cp_q;
endmodule

// File: rtl/bus_xcvr_cell.sv
module bus_xcvr_cell
    import bus_xcvr_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  path_ctl_t         ctl,
    input  logic              cp_rise,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q,
    output logic [DATA_W-1:0] dout
);
    cell_op_t op;

    always_comb begin
        op = pick_op(ctl.le, cp_rise, ctl.ce_n);
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (op != CELL_HOLD)
            q <= din;
    end

    assign dout = ctl.le ? din : q;

    assert_track_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.le |=> q == $past(din));
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!ctl.le && !cp_rise) |=> $stable(q));
    assert_load_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctl.le && cp_rise && !ctl.ce_n) |=> q == $past(din));
    assert_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (!ctl.le && ctl.ce_n) |=> $stable(q));
    assert_clear_R8: assert property (@(posedge clk)
        rst |=> q == '0);
endmodule

// File: rtl/bus_xcvr_path.sv
module bus_xcvr_path
    import bus_xcvr_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  path_ctl_t         ctl,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              oe
);
    logic              cp_rise;
    logic [DATA_W-1:0] q;

    bus_xcvr_edge u_edge (
        .clk  (clk),
        .cp   (ctl.cp),
        .rise (cp_rise)
    );

    bus_xcvr_cell #(.DATA_W(DATA_W)) u_cell (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .cp_rise (cp_rise),
        .din     (din),
        .q       (q),
        .dout    (dout)
    );

    assign oe = ~ctl.oe_n & ~rst;

    assert_pass_R1: assert property (@(posedge clk) disable iff (rst)
        ctl.le |-> dout == din);
    assert_hiz_R6: assert property (@(posedge clk)
        ctl.oe_n |-> !oe);
    assert_rst_off_R8: assert property (@(posedge clk)
        rst |-> !oe);
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
    import bus_xcvr_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              ab_oe_n,
    input  logic              ab_le,
    input  logic              ab_cp,
    input  logic              ab_ce_n,
    input  logic              ba_oe_n,
    input  logic              ba_le,
    input  logic              ba_cp,
    input  logic              ba_ce_n,
    output logic [DATA_W-1:0] b_out,
    output logic              b_oe,
    output logic [DATA_W-1:0] a_out,
    output logic              a_oe
);
    localparam int LAST_PATH = NUM_PATHS - 1;

    path_ctl_t         ctl  [NUM_PATHS];
    logic [DATA_W-1:0] din  [NUM_PATHS];
    logic [DATA_W-1:0] dout [NUM_PATHS];
    logic              oe   [NUM_PATHS];

    // index 0: A toward B, index LAST_PATH: B toward A
    assign ctl[0]         = '{oe_n: ab_oe_n, le: ab_le, cp: ab_cp, ce_n: ab_ce_n};
    assign ctl[LAST_PATH] = '{oe_n: ba_oe_n, le: ba_le, cp: ba_cp, ce_n: ba_ce_n};
    assign din[0]         = a_in;
    assign din[LAST_PATH] = b_in;

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        bus_xcvr_path #(.DATA_W(DATA_W)) u_path (
            .clk  (clk),
            .rst  (rst),
            .ctl  (ctl[p]),
            .din  (din[p]),
            .dout (dout[p]),
            .oe   (oe[p])
        );
    end

    assign b_out = dout[0];
    assign b_oe  = oe[0];
    assign a_out = dout[LAST_PATH];
    assign a_oe  = oe[LAST_PATH];
endmodule

// File: tb/tb_bus_xcvr.sv
module tb_bus_xcvr;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic ab_oe_n = 1'b1, ab_le = 1'b0, ab_cp = 1'b0, ab_ce_n = 1'b1;
    logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_cp = 1'b0, ba_ce_n = 1'b1;
    logic [W-1:0] b_out, a_out;
    logic         b_oe, a_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    bus_xcvr #(.DATA_W(W)) dut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_cp(ab_cp), .ab_ce_n(ab_ce_n),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_cp(ba_cp), .ba_ce_n(ba_ce_n),
        .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe)
    );

    typedef struct packed {
        logic [3:0]   req;
        logic         le;
        logic         cp;
        logic         ce_n;
        logic         oe_n;
        logic [W-1:0] d;
        logic         exp_oe;
        logic [W-1:0] exp_out;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 1'b1, 1'b0, 1'b1, 1'b0, 18'h12345, 1'b1, 18'h12345}, // R1 pass
        '{4'd1, 1'b1, 1'b0, 1'b1, 1'b0, 18'h3FFFF, 1'b1, 18'h3FFFF}, // R1 all ones
        '{4'd2, 1'b0, 1'b0, 1'b1, 1'b0, 18'h00001, 1'b1, 18'h3FFFF}, // R2 le falls, cp low
        '{4'd5, 1'b0, 1'b1, 1'b1, 1'b0, 18'h00002, 1'b1, 18'h3FFFF}, // R5 edge blocked
        '{4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 18'h00003, 1'b1, 18'h3FFFF}, // R3 cp low
        '{4'd4, 1'b0, 1'b1, 1'b0, 1'b0, 18'h2AAAA, 1'b1, 18'h2AAAA}, // R4 capture
        '{4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 18'h15555, 1'b1, 18'h2AAAA}, // R3 cp high
        '{4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 18'h15555, 1'b1, 18'h2AAAA}, // R3 cp low
        '{4'd4, 1'b0, 1'b1, 1'b0, 1'b1, 18'h15555, 1'b0, 18'h15555}, // R4 capture while off
        '{4'd6, 1'b1, 1'b0, 1'b0, 1'b1, 18'h0F0F0, 1'b0, 18'h0F0F0}, // R6 pass, disabled
        '{4'd6, 1'b1, 1'b0, 1'b0, 1'b0, 18'h0F0F0, 1'b1, 18'h0F0F0}, // R6 enable in pass
        '{4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 18'h00FF0, 1'b1, 18'h00FF0}, // R1 cp high in pass
        '{4'd9, 1'b0, 1'b1, 1'b0, 1'b0, 18'h11111, 1'b1, 18'h00FF0}, // R9 le falls, cp high
        '{4'd9, 1'b0, 1'b0, 1'b0, 1'b0, 18'h22222, 1'b1, 18'h00FF0}  // R9 still held
    };

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        ab_oe_n = 1'b1; ab_le = 1'b0; ab_cp = 1'b0; ab_ce_n = 1'b1;
        ba_oe_n = 1'b1; ba_le = 1'b0; ba_cp = 1'b0; ba_ce_n = 1'b1;
        a_in = '0; b_in = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_all();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 50000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R8: reset state, enables low
        idle_all();
        ab_oe_n = 1'b0; ba_oe_n = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        check("R8 b_oe in reset", W'(b_oe), W'(0));
        check("R8 a_oe in reset", W'(a_oe), W'(0));

        for (int dir = 0; dir < 2; dir++) begin
            do_reset();
            for (int i = 0; i < NV; i++) begin
                string tag;
                tag = $sformatf("R%0d dir%0d vec%0d", VECS[i].req, dir, i);
                if (dir == 0) begin
                    ab_le = VECS[i].le; ab_cp = VECS[i].cp;
                    ab_ce_n = VECS[i].ce_n; ab_oe_n = VECS[i].oe_n;
                    a_in = VECS[i].d; b_in = ~VECS[i].d;
                end else begin
                    ba_le = VECS[i].le; ba_cp = VECS[i].cp;
                    ba_ce_n = VECS[i].ce_n; ba_oe_n = VECS[i].oe_n;
                    b_in = VECS[i].d; a_in = ~VECS[i].d;
                end
                @(posedge clk);
                #2;
                if (dir == 0) begin
                    check(tag, b_out, VECS[i].exp_out);
                    check(tag, W'(b_oe), W'(VECS[i].exp_oe));
                    check("R7 idle a_out", a_out, W'(0));
                    check("R7 idle a_oe", W'(a_oe), W'(0));
                end else begin
                    check(tag, a_out, VECS[i].exp_out);
                    check(tag, W'(a_oe), W'(VECS[i].exp_oe));
                    check("R7 idle b_out", b_out, W'(0));
                    check("R7 idle b_oe", W'(b_oe), W'(0));
                end
                @(negedge clk);
            end
        end

        // R9: after cp goes low, the next rise captures again
        @(negedge clk);
        ba_le = 1'b0; ba_ce_n = 1'b0; ba_oe_n = 1'b0; ba_cp = 1'b1; b_in = 18'h3C3C3;
        @(posedge clk); #2;
        check("R9 rise after low captures", a_out, 18'h3C3C3);

        // R8: reset mid-operation clears storage and disables output
        @(negedge clk);
        ba_cp = 1'b0; b_in = 18'h0;
        rst = 1'b1;
        @(posedge clk); #2;
        check("R8 a_oe during reset", W'(a_oe), W'(0));
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #2;
        b_in = 18'h1FFFF;
        #1;
        check("R8 storage cleared", a_out, W'(0));
        check("R8 enable back", W'(a_oe), W'(1));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule